// File: doc/BRIEF.md
# Cascadable Parity Generator and Checker Cell

This cell is purely combinational. It XOR-reduces a data word (eight bits by default) and combines that parity with two steering inputs, an even-steer and an odd-steer. The result appears on two outputs, an even-sum and an odd-sum. With exactly one steering input high, the two outputs are complements of each other and report the parity of the word. Tying both steering inputs to the same level forces both outputs to a fixed value, whatever the data.

The cell has three uses. It checks parity on a received word. It produces the check bit for a word about to be sent. It can also sit in a chain: the even-sum and odd-sum of one cell drive the even-steer and odd-steer of the next, which extends the parity over a multiple of the word width. The width of the reduction network and its structure are parameters. The output function does not depend on them.

Top module: `parity_cascade_cell`

## Requirements
- R1: With even-steer=1 and odd-steer=0 and an even number of ones in the data, even-sum=1 and odd-sum=0.
- R2: With even-steer=1 and odd-steer=0 and an odd number of ones in the data, even-sum=0 and odd-sum=1.
- R3: With even-steer=0 and odd-steer=1, even-sum=0 and odd-sum=1 when the data holds an even number of ones, and even-sum=1 and odd-sum=0 when it holds an odd number.
- R4: With both steering inputs at 1, both outputs are 0 for every data value.
- R5: With both steering inputs at 0, both outputs are 1 for every data value.
- R6: Whenever exactly one steering input is high, even-sum and odd-sum are complements of each other.
- R7: When a second cell takes the first cell's even-sum and odd-sum as its even-steer and odd-steer, the second cell's outputs follow R1 to R5, using the combined parity of both data words and the first cell's steering.
- R8: With even-steer=0 and odd-steer=1, odd-sum taken as a check bit makes the total count of ones across the data plus that bit odd.
- R9: Every supported reduction structure (RED_STYLE 0 balanced tree, 1 flat reduction, 2 ripple chain) gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W | Word whose ones are counted |
| even_steer_i | input | 1 | Cascade steering input, even side |
| odd_steer_i | input | 1 | Cascade steering input, odd side |
| even_sum_o | output | 1 | Even-side parity result |
| odd_sum_o | output | 1 | Odd-side parity result |

## Verification
Immediate assertions in the top module are evaluated on every change of the inputs. They cover the forced outputs of the two illegal steering codes, the complementary outputs in the legal codes, and the match between odd-sum and the data parity in each legal code. Only the bench scenarios can show that all 256 data words, under all four steering codes, give the right values. The same holds for the two-cell chain over sixteen bits, for the check-bit property of odd generation, and for agreement between the three reduction structures, which the bench shows by instantiating each one.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   // bit 1 = even-steer, bit 0 = odd-steer
   typedef enum logic [1:0] {
      STEER_BOTH_LOW  = 2'b00,
      STEER_ODD       = 2'b01,
      STEER_EVEN      = 2'b10,
      STEER_BOTH_HIGH = 2'b11
   } steer_mode_e;

   localparam int unsigned RED_TREE   = 0;
   localparam int unsigned RED_FLAT   = 1;
   localparam int unsigned RED_RIPPLE = 2;

endpackage

// File: rtl/pcc_xor_reduce.sv
module pcc_xor_reduce #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned STYLE = 0
) (
   input  logic [WIDTH-1:0] bits_i,
   output logic             odd_o
);
   import pcc_pkg::*;

   localparam int unsigned LVL  = (WIDTH > 1) ? $clog2(WIDTH) : 0;
   localparam int unsigned PADW = 1 << LVL;
   localparam int unsigned NODES = 2 * PADW - 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("pcc_xor_reduce: WIDTH must be at least 1");
      end
      if (STYLE > RED_RIPPLE) begin : g_bad_style
         $error("pcc_xor_reduce: unknown STYLE");
      end

      if (STYLE == RED_TREE) begin : g_tree
         logic [NODES-1:0] node;
         for (genvar j = 0; j < PADW; j++) begin : g_leaf
            if (j < WIDTH) begin : g_real
               assign node[PADW-1+j] = bits_i[j];
            end else begin : g_pad
               assign node[PADW-1+j] = 1'b0;
            end
         end
         for (genvar n = 0; n < PADW - 1; n++) begin : g_inner
            assign node[n] = node[2*n+1] ^ node[2*n+2];
         end
         assign odd_o = node[0];
      end else if (STYLE == RED_FLAT) begin : g_flat
         assign odd_o = ^bits_i;
      end else begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = 1'b0;
         for (genvar k = 0; k < WIDTH; k++) begin : g_stage
            assign chain[k+1] = chain[k] ^ bits_i[k];
         end
         assign odd_o = chain[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/pcc_steer.sv
module pcc_steer
   import pcc_pkg::*;
(
   input  steer_mode_e mode_i,
   input  logic        odd_cnt_i,
   output logic        even_sum_o,
   output logic        odd_sum_o
);

   always_comb begin
      unique case (mode_i)
         STEER_EVEN: begin
            even_sum_o = ~odd_cnt_i;
            odd_sum_o  =  odd_cnt_i;
         end
         STEER_ODD: begin
            even_sum_o =  odd_cnt_i;
            odd_sum_o  = ~odd_cnt_i;
         end
         STEER_BOTH_HIGH: begin
            even_sum_o = 1'b0;
            odd_sum_o  = 1'b0;
         end
         default: begin
            even_sum_o = 1'b1;
            odd_sum_o  = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/parity_cascade_cell.sv
module parity_cascade_cell #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RED_STYLE = 0
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              even_steer_i,
   input  logic              odd_steer_i,
   output logic              even_sum_o,
   output logic              odd_sum_o
);
   import pcc_pkg::*;

   generate
      if (DATA_W < 1) begin : g_chk_w
         $error("parity_cascade_cell: DATA_W must be at least 1");
      end
   endgenerate

   logic        word_odd;
   steer_mode_e mode;

   assign mode = steer_mode_e'({even_steer_i, odd_steer_i});

   pcc_xor_reduce #(
      .WIDTH (DATA_W),
      .STYLE (RED_STYLE)
   ) u_reduce (
      .bits_i (data_i),
      .odd_o  (word_odd)
   );

   pcc_steer u_steer (
      .mode_i     (mode),
      .odd_cnt_i  (word_odd),
      .even_sum_o (even_sum_o),
      .odd_sum_o  (odd_sum_o)
   );

   always_comb begin
      if (even_steer_i && odd_steer_i) begin
         p_both_high_zero_r4: assert (!even_sum_o && !odd_sum_o)
            else $error("both-high steering must force zeros");
      end
      if (!even_steer_i && !odd_steer_i) begin
         p_both_low_one_r5: assert (even_sum_o && odd_sum_o)
            else $error("both-low steering must force ones");
      end
      if (even_steer_i != odd_steer_i) begin
         p_complement_r6: assert (even_sum_o != odd_sum_o)
            else $error("outputs not complementary");
      end
      if (even_steer_i && !odd_steer_i) begin
         p_even_mode_r2: assert (odd_sum_o == (^data_i))
            else $error("even steering: odd-sum differs from data parity");
      end
      if (!even_steer_i && odd_steer_i) begin
         p_odd_mode_r3: assert (odd_sum_o == !(^data_i))
            else $error("odd steering: odd-sum differs from inverted parity");
      end
   end

endmodule

// File: tb/parity_cascade_cell_tb.sv
module parity_cascade_cell_tb;

   localparam int unsigned W = 8;

   typedef struct {
      logic [W-1:0] lo;
      logic [W-1:0] hi;
      logic         es;
      logic         os;
      logic         exp_e;
      logic         exp_o;
      logic         exp_he;
      logic         exp_ho;
      string        tag;
   } item_t;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [W-1:0] data_lo = '0;
   logic [W-1:0] data_hi = '0;
   logic es = 1'b0;
   logic os = 1'b0;
   logic e_t, o_t, e_f, o_f, e_r, o_r, e_h, o_h;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;
   item_t q[$];

   parity_cascade_cell #(.DATA_W(W), .RED_STYLE(0)) u_dut (
      .data_i(data_lo), .even_steer_i(es), .odd_steer_i(os),
      .even_sum_o(e_t), .odd_sum_o(o_t));

   parity_cascade_cell #(.DATA_W(W), .RED_STYLE(1)) u_flat (
      .data_i(data_lo), .even_steer_i(es), .odd_steer_i(os),
      .even_sum_o(e_f), .odd_sum_o(o_f));

   parity_cascade_cell #(.DATA_W(W), .RED_STYLE(2)) u_ripple (
      .data_i(data_lo), .even_steer_i(es), .odd_steer_i(os),
      .even_sum_o(e_r), .odd_sum_o(o_r));

   parity_cascade_cell #(.DATA_W(W), .RED_STYLE(0)) u_upper (
      .data_i(data_hi), .even_steer_i(e_t), .odd_steer_i(o_t),
      .even_sum_o(e_h), .odd_sum_o(o_h));

   function automatic void model(input logic p, input logic se, input logic so,
                                 output logic ee, output logic eo);
      case ({se, so})
         2'b10:   begin ee = !p; eo = p;  end
         2'b01:   begin ee = p;  eo = !p; end
         2'b11:   begin ee = 1'b0; eo = 1'b0; end
         default: begin ee = 1'b1; eo = 1'b1; end
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [W-1:0] lo, input logic [W-1:0] hi,
                        input logic se, input logic so);
      item_t it;
      logic p;
      @(posedge clk);
      data_lo = lo; data_hi = hi; es = se; os = so;
      p = ^lo;
      it.lo = lo; it.hi = hi; it.es = se; it.os = so;
      model(p, se, so, it.exp_e, it.exp_o);
      model(^hi, it.exp_e, it.exp_o, it.exp_he, it.exp_ho);
      case ({se, so})
         2'b10:   it.tag = p ? "R2" : "R1";
         2'b01:   it.tag = "R3";
         2'b11:   it.tag = "R4";
         default: it.tag = "R5";
      endcase
      q.push_back(it);
   endtask

   // monitor: compare half a period after the inputs change
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, "even_sum", e_t, it.exp_e);
            check(it.tag, "odd_sum",  o_t, it.exp_o);
            if (it.es != it.os)
               check("R6", "complement", e_t ^ o_t, 1'b1);
            if (!it.es && it.os)
               check("R8", "ones incl. check bit odd", ^{it.lo, o_t}, 1'b1);
            check("R9", "flat even", e_f, it.exp_e);
            check("R9", "flat odd", o_f, it.exp_o);
            check("R9", "ripple even", e_r, it.exp_e);
            check("R9", "ripple odd", o_r, it.exp_o);
            check("R7", "chain even", e_h, it.exp_he);
            check("R7", "chain odd", o_h, it.exp_ho);
         end
      end
   end

   initial begin
      // state at start: all inputs low, both outputs forced high (R5)
      #5;
      check("R5", "start even_sum", e_t, 1'b1);
      check("R5", "start odd_sum",  o_t, 1'b1);
      for (int m = 0; m < 4; m++) begin
         for (int d = 0; d < 256; d++) begin
            drive(W'(d), W'((d * 37 + m * 11) & 8'hFF), m[1], m[0]);
         end
      end
      // chain boundary words
      drive(8'hFF, 8'hFF, 1'b1, 1'b0);
      drive(8'h01, 8'h00, 1'b1, 1'b0);
      drive(8'h00, 8'h80, 1'b0, 1'b1);
      drive(8'hFE, 8'h7F, 1'b0, 1'b1);
      @(posedge clk);
      @(posedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule